// File: doc/BRIEF.md
# UART DMA Request Line Generator

This block drives the two active-low DMA request lines of one UART channel: a receive request (`rx_rdy_n`) that asks a DMA engine to drain received characters, and a transmit request (`tx_rdy_n`) that asks it to supply characters to send. It does not hold the data. The receive buffer occupancy, the trigger-level hit, the character timeout, the transmit buffer occupancy and the transmit-full flag all come in as inputs. Two configuration inputs come from the channel's buffer control register: one enables buffered (FIFO) operation and one asks for block-transfer handshaking.

Two handshake styles exist. Single-transfer style makes a request whenever there is something to move. Block style latches a request at a threshold and releases it only at the opposite extreme: a full receive drain, or a full transmit buffer. Block style is honoured only while buffering is enabled. With buffering off the block always uses single-transfer style, and the receive path sees a plain one-character holding register. In buffered operation a receive request is held back for a fixed number of clock cycles after the data or the threshold event first appears. A request is always withdrawn on the next clock edge.

Top module: `uart_dma_req`

## Requirements
- R1: While `rst_n` is low at a clock edge, `rx_rdy_n` becomes 1 and `tx_rdy_n` becomes 0 (an empty transmitter is ready).
- R2: When `fifo_en` is 0, `dma_mode_sel` has no effect and both lines follow the single-transfer rules.
- R3: With `fifo_en`=0, `rx_rdy_n` is 0 after an edge that samples `rx_level`≠0 and 1 after an edge that samples `rx_level`=0.
- R4: With `fifo_en`=1 and `dma_mode_sel`=0, `rx_rdy_n` goes to 0 on the RX_DLY-th consecutive edge (default 3) that samples `rx_level`≠0. It returns to 1 on the first edge that samples `rx_level`=0. A gap in occupancy restarts the count.
- R5: With `fifo_en`=1 and `dma_mode_sel`=1, `rx_rdy_n` goes to 0 only on the RX_DLY-th consecutive edge at which (`rx_trig_hit` or `rx_timeout`) is 1 and `rx_level`≠0. It then stays 0 while `rx_level`≠0, even after the threshold inputs fall.
- R6: In block style, an edge that samples `rx_level`=0 drives `rx_rdy_n` to 1, even if a threshold input is 1 at that edge.
- R7: In single-transfer style, `tx_rdy_n` is 0 after an edge that samples `tx_level`=0 and 1 after an edge that samples `tx_level`≠0.
- R8: In block style, `tx_rdy_n` becomes 0 after an edge that samples `tx_level`=0 and becomes 1 after an edge that samples `tx_full`=1. Otherwise it keeps its value.
- R9: In single-transfer style, `tx_full` has no effect on `tx_rdy_n`.
- R10: In block style, `rx_timeout` alone (with `rx_trig_hit`=0) raises a receive request under the same delay as a trigger hit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Channel clock |
| rst_n | input | 1 | Synchronous reset, active low |
| fifo_en | input | 1 | Buffered operation enable |
| dma_mode_sel | input | 1 | Block-transfer handshake request (used only when `fifo_en`=1) |
| rx_level | input | RX_CNT_W | Characters waiting in the receive buffer or holding register |
| rx_trig_hit | input | 1 | Receive occupancy has reached the trigger level |
| rx_timeout | input | 1 | Receive character timeout has expired |
| tx_level | input | TX_CNT_W | Characters waiting in the transmit buffer or holding register |
| tx_full | input | 1 | Transmit buffer is completely full |
| rx_rdy_n | output | 1 | Receive DMA request, active low |
| tx_rdy_n | output | 1 | Transmit DMA request, active low |

## Verification
The bench counts out the receive hold-off edge by edge. It also breaks occupancy for one cycle in the middle of that count, so a design that samples a single old value in place of a continuous run would raise the request too early. It sets the block-transfer bit while buffering is off, which catches a design that lets that bit act without buffering (the receive request would stay silent with data present). In block style it drops the threshold while data remains, and it empties the buffer in the same cycle that the trigger is asserted. These steps expose a request that fails to hold, or a set that wins over the clear. On transmit it walks the level through values that are neither empty nor full, so a design that deasserts early would show up.

// File: rtl/uart_dma_req_pkg.sv
// Shared types for the UART DMA request generator.
package uart_dma_req_pkg;

    // Handshake style in effect for both request lines.
    typedef enum logic {
        STYLE_SINGLE = 1'b0,   // request whenever anything can move
        STYLE_BLOCK  = 1'b1    // latched request, released at the opposite extreme
    } dma_style_e;

endpackage

// File: rtl/uart_dma_req_mode_sel.sv
// Resolves the handshake style from the two configuration bits.
// Assumes: block style is legal only while buffered operation is on.
module uart_dma_req_mode_sel
    import uart_dma_req_pkg::*;
(
    input  logic       fifo_en,
    input  logic       mode_bit,
    output dma_style_e style,
    output logic       buffered
);

    // Block style needs buffering; otherwise fall back to single transfers.
    always_comb begin
        buffered = fifo_en;
        style    = (fifo_en && mode_bit) ? STYLE_BLOCK : STYLE_SINGLE;
    end

endmodule

// File: rtl/uart_dma_req_run_dly.sv
// Run-length qualifier: q is 1 once d has been 1 at STAGES consecutive
// clock edges. A single 0 clears the whole chain.
// Assumes: STAGES >= 1.
module uart_dma_req_run_dly #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);

    logic [STAGES-1:0] run_q;

    genvar gi;
    generate
        for (gi = 0; gi < STAGES; gi++) begin : g_stage
            if (gi == 0) begin : g_head
                // First stage records the current sample.
                always_ff @(posedge clk) begin
                    if (!rst_n) run_q[0] <= 1'b0;
                    else        run_q[0] <= d;
                end
            end else begin : g_body
                // Later stages advance only while the run is unbroken.
                always_ff @(posedge clk) begin
                    if (!rst_n) run_q[gi] <= 1'b0;
                    else        run_q[gi] <= run_q[gi-1] && d;
                end
            end
        end
    endgenerate

    assign q = run_q[STAGES-1];

endmodule

// File: rtl/uart_dma_req_rx_gen.sv
// Receive request line. In single style it tracks occupancy, delayed in
// buffered operation. In block style it latches on a delayed threshold
// event and releases only when the receive side drains.
// Assumes: DLY >= 2 total edges for the buffered hold-off.
module uart_dma_req_rx_gen
    import uart_dma_req_pkg::*;
#(
    parameter int DLY = 3
) (
    input  logic       clk,
    input  logic       rst_n,
    input  dma_style_e style,
    input  logic       buffered,
    input  logic       present,
    input  logic       thresh,
    output logic       rdy_n
);

    localparam int PRE_STAGES = DLY - 1;

    logic pres_run;
    logic thr_run;
    logic avail;
    logic set_req;
    logic rdy_n_q;
    logic rdy_n_d;

    uart_dma_req_run_dly #(.STAGES(PRE_STAGES)) u_pres_dly (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (present),
        .q     (pres_run)
    );

    uart_dma_req_run_dly #(.STAGES(PRE_STAGES)) u_thr_dly (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (present && thresh),
        .q     (thr_run)
    );

    // Qualified data-available and latched-set conditions.
    always_comb begin
        avail   = buffered ? (present && pres_run) : present;
        set_req = present && thresh && thr_run;
    end

    // Next-state rule per style; a drained receiver always wins.
    always_comb begin
        if (style == STYLE_BLOCK) begin
            if (!present)     rdy_n_d = 1'b1;
            else if (set_req) rdy_n_d = 1'b0;
            else              rdy_n_d = rdy_n_q;
        end else begin
            rdy_n_d = !avail;
        end
    end

    // Output register, doubling as the block-style latch.
    always_ff @(posedge clk) begin
        if (!rst_n) rdy_n_q <= 1'b1;
        else        rdy_n_q <= rdy_n_d;
    end

    assign rdy_n = rdy_n_q;

endmodule

// File: rtl/uart_dma_req_tx_gen.sv
// Transmit request line. Single style requests while empty. Block style
// latches at empty and releases only at full.
// Assumes: empty and full are never both true.
module uart_dma_req_tx_gen
    import uart_dma_req_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  dma_style_e style,
    input  logic       empty,
    input  logic       full,
    output logic       rdy_n
);

    logic rdy_n_q;
    logic rdy_n_d;

    // Next-state rule per style; empty takes priority in block style.
    always_comb begin
        if (style == STYLE_BLOCK) begin
            if (empty)     rdy_n_d = 1'b0;
            else if (full) rdy_n_d = 1'b1;
            else           rdy_n_d = rdy_n_q;
        end else begin
            rdy_n_d = !empty;
        end
    end

    // Output register; reset reflects an empty transmitter.
    always_ff @(posedge clk) begin
        if (!rst_n) rdy_n_q <= 1'b0;
        else        rdy_n_q <= rdy_n_d;
    end

    assign rdy_n = rdy_n_q;

endmodule

// File: rtl/uart_dma_req.sv
// Top of the UART DMA request generator for one channel.
// Assumes: buffer levels, trigger hit, timeout and full flag are
// synchronous to clk and come from the channel's buffer logic.
module uart_dma_req
    import uart_dma_req_pkg::*;
#(
    parameter int RX_CNT_W = 5,
    parameter int TX_CNT_W = 5,
    parameter int RX_DLY   = 3
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                fifo_en,
    input  logic                dma_mode_sel,
    input  logic [RX_CNT_W-1:0] rx_level,
    input  logic                rx_trig_hit,
    input  logic                rx_timeout,
    input  logic [TX_CNT_W-1:0] tx_level,
    input  logic                tx_full,
    output logic                rx_rdy_n,
    output logic                tx_rdy_n
);

    dma_style_e style;
    logic       buffered;
    logic       rx_present;
    logic       rx_thresh;
    logic       tx_empty;

    // Occupancy and threshold summaries.
    always_comb begin
        rx_present = (rx_level != '0);
        rx_thresh  = rx_trig_hit || rx_timeout;
        tx_empty   = (tx_level == '0);
    end

    uart_dma_req_mode_sel u_mode (
        .fifo_en  (fifo_en),
        .mode_bit (dma_mode_sel),
        .style    (style),
        .buffered (buffered)
    );

    uart_dma_req_rx_gen #(.DLY(RX_DLY)) u_rx (
        .clk      (clk),
        .rst_n    (rst_n),
        .style    (style),
        .buffered (buffered),
        .present  (rx_present),
        .thresh   (rx_thresh),
        .rdy_n    (rx_rdy_n)
    );

    uart_dma_req_tx_gen u_tx (
        .clk   (clk),
        .rst_n (rst_n),
        .style (style),
        .empty (tx_empty),
        .full  (tx_full),
        .rdy_n (tx_rdy_n)
    );

endmodule

// File: rtl/uart_dma_req_chk.sv
// Property checker for uart_dma_req, attached by bind.
module uart_dma_req_chk #(
    parameter int RX_CNT_W = 5,
    parameter int TX_CNT_W = 5,
    parameter int RX_DLY   = 3
) (
    input logic                clk,
    input logic                rst_n,
    input logic                fifo_en,
    input logic                dma_mode_sel,
    input logic [RX_CNT_W-1:0] rx_level,
    input logic                rx_trig_hit,
    input logic                rx_timeout,
    input logic [TX_CNT_W-1:0] tx_level,
    input logic                tx_full,
    input logic                rx_rdy_n,
    input logic                tx_rdy_n
);

    localparam int RUN_W = $clog2(RX_DLY + 1) + 1;

    logic [RUN_W-1:0] occ_run;

    // Consecutive edges with receive data present, saturating.
    always_ff @(posedge clk) begin
        if (!rst_n)                 occ_run <= '0;
        else if (rx_level == '0)    occ_run <= '0;
        else if (occ_run < RUN_W'(RX_DLY)) occ_run <= occ_run + 1'b1;
    end

    // R1
    reset_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (rx_rdy_n && !tx_rdy_n));

    // R3
    plain_rx_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(!fifo_en)) |-> (rx_rdy_n == ($past(rx_level) == '0)));

    // R4
    rx_holdoff_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(rx_rdy_n) && $past(fifo_en && !dma_mode_sel)) |-> (occ_run >= RUN_W'(RX_DLY)));

    // R5
    rx_latch_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(fifo_en && dma_mode_sel && rx_level != '0 && !rx_rdy_n)) |-> !rx_rdy_n);

    // R6
    rx_drain_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(fifo_en && dma_mode_sel && rx_level == '0)) |-> rx_rdy_n);

    // R7
    tx_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(!(fifo_en && dma_mode_sel))) |-> (tx_rdy_n == ($past(tx_level) != '0)));

    // R8
    tx_block_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(fifo_en && dma_mode_sel && tx_level != '0 && !tx_full))
            |-> (tx_rdy_n == $past(tx_rdy_n)));

    // R8
    tx_block_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(fifo_en && dma_mode_sel && tx_level != '0 && tx_full)) |-> tx_rdy_n);

    // Threshold inputs are only meaningful in the checker through R10 stimulus.
    logic unused_ok;
    assign unused_ok = rx_trig_hit ^ rx_timeout;

endmodule

bind uart_dma_req uart_dma_req_chk #(
    .RX_CNT_W (RX_CNT_W),
    .TX_CNT_W (TX_CNT_W),
    .RX_DLY   (RX_DLY)
) chk_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .fifo_en      (fifo_en),
    .dma_mode_sel (dma_mode_sel),
    .rx_level     (rx_level),
    .rx_trig_hit  (rx_trig_hit),
    .rx_timeout   (rx_timeout),
    .tx_level     (tx_level),
    .tx_full      (tx_full),
    .rx_rdy_n     (rx_rdy_n),
    .tx_rdy_n     (tx_rdy_n)
);

// File: tb/uart_dma_req_tb_top.sv
// Scoreboard bench: the driver pushes expected levels for the next edge,
// and the monitor pops and compares just after that edge.
module uart_dma_req_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       fifo_en = 1'b0;
    logic       dma_mode_sel = 1'b0;
    logic [4:0] rx_level = '0;
    logic       rx_trig_hit = 1'b0;
    logic       rx_timeout = 1'b0;
    logic [4:0] tx_level = '0;
    logic       tx_full = 1'b0;
    logic       rx_rdy_n;
    logic       tx_rdy_n;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    bit    exp_rx_q[$];
    bit    exp_tx_q[$];
    string tag_q[$];

    always #4 clk = ~clk;

    uart_dma_req dut_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .fifo_en      (fifo_en),
        .dma_mode_sel (dma_mode_sel),
        .rx_level     (rx_level),
        .rx_trig_hit  (rx_trig_hit),
        .rx_timeout   (rx_timeout),
        .tx_level     (tx_level),
        .tx_full      (tx_full),
        .rx_rdy_n     (rx_rdy_n),
        .tx_rdy_n     (tx_rdy_n)
    );

    task automatic check_now(input string tag, input bit erx, input bit etx);
        total += 2;
        if (rx_rdy_n !== erx) begin
            bad++;
            $display("FAIL %s rx_rdy_n got=%0b exp=%0b", tag, rx_rdy_n, erx);
        end
        if (tx_rdy_n !== etx) begin
            bad++;
            $display("FAIL %s tx_rdy_n got=%0b exp=%0b", tag, tx_rdy_n, etx);
        end
    endtask

    // Drive one cycle of inputs and queue the levels expected after the edge.
    task automatic step(input bit fe, input bit md, input logic [4:0] rxl,
                        input bit trg, input bit tmo, input logic [4:0] txl,
                        input bit full, input bit erx, input bit etx,
                        input string tag);
        @(negedge clk);
        fifo_en      = fe;
        dma_mode_sel = md;
        rx_level     = rxl;
        rx_trig_hit  = trg;
        rx_timeout   = tmo;
        tx_level     = txl;
        tx_full      = full;
        exp_rx_q.push_back(erx);
        exp_tx_q.push_back(etx);
        tag_q.push_back(tag);
    endtask

    // Monitor: compare just after each edge against the oldest expectation.
    always @(posedge clk) begin
        #2;
        if (exp_rx_q.size() > 0) begin
            check_now(tag_q.pop_front(), exp_rx_q.pop_front(), exp_tx_q.pop_front());
        end
    end

    task automatic finish_run();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check_now("R1 reset", 1'b1, 1'b0);
        rst_n = 1'b1;

        // R3: plain holding register
        step(0,0, 1,0,0, 0,0, 0,0, "R3 data in");
        step(0,0, 0,0,0, 0,0, 1,0, "R3 drained");
        // R2: block bit ignored without buffering
        step(0,1, 1,0,0, 0,0, 0,0, "R2 rx single");
        // R7: transmit single style
        step(0,1, 0,0,0, 1,0, 1,1, "R7 tx loaded");
        step(0,1, 0,0,0, 0,0, 1,0, "R7 tx empty");
        step(0,1, 0,0,0, 5,0, 1,1, "R2 tx single");
        step(0,0, 0,0,0, 0,0, 1,0, "R7 tx empty again");

        // R4: buffered single style hold-off
        step(1,0, 2,0,0, 0,0, 1,0, "R4 edge1");
        step(1,0, 2,0,0, 0,0, 1,0, "R4 edge2");
        step(1,0, 2,0,0, 0,0, 0,0, "R4 edge3");
        step(1,0, 0,0,0, 0,0, 1,0, "R4 drain");
        step(1,0, 1,0,0, 0,0, 1,0, "R4 gap a");
        step(1,0, 0,0,0, 0,0, 1,0, "R4 gap b");
        step(1,0, 1,0,0, 0,0, 1,0, "R4 restart1");
        step(1,0, 1,0,0, 0,0, 1,0, "R4 restart2");
        step(1,0, 1,0,0, 0,0, 0,0, "R4 restart3");
        step(1,0, 0,0,0, 0,0, 1,0, "R4 drain2");
        // R9: full flag ignored in single style
        step(1,0, 0,0,0, 3,0, 1,1, "R9 tx loaded");
        step(1,0, 0,0,0, 3,1, 1,1, "R9 full seen");
        step(1,0, 0,0,0, 0,1, 1,0, "R9 empty with full");
        step(1,0, 0,0,0, 0,0, 1,0, "R9 empty");

        // R5: block style receive
        step(1,1, 4,0,0, 0,0, 1,0, "R5 no thresh1");
        step(1,1, 4,0,0, 0,0, 1,0, "R5 no thresh2");
        step(1,1, 4,0,0, 0,0, 1,0, "R5 no thresh3");
        step(1,1, 4,0,0, 0,0, 1,0, "R5 no thresh4");
        step(1,1, 8,1,0, 0,0, 1,0, "R5 trig1");
        step(1,1, 8,1,0, 0,0, 1,0, "R5 trig2");
        step(1,1, 8,1,0, 0,0, 0,0, "R5 trig3");
        step(1,1, 5,0,0, 0,0, 0,0, "R5 hold1");
        step(1,1, 5,0,0, 0,0, 0,0, "R5 hold2");
        // R6: drain wins over trigger
        step(1,1, 0,1,0, 0,0, 1,0, "R6 drain with trig");
        step(1,1, 0,0,0, 0,0, 1,0, "R6 idle");
        // R10: timeout alone
        step(1,1, 2,0,1, 0,0, 1,0, "R10 tmo1");
        step(1,1, 2,0,1, 0,0, 1,0, "R10 tmo2");
        step(1,1, 2,0,1, 0,0, 0,0, "R10 tmo3");
        step(1,1, 2,0,0, 0,0, 0,0, "R10 hold");
        step(1,1, 0,0,0, 0,0, 1,0, "R6 drain");

        // R8: block style transmit
        step(1,1, 0,0,0, 1,0, 1,0, "R8 partial1");
        step(1,1, 0,0,0, 8,0, 1,0, "R8 partial8");
        step(1,1, 0,0,0, 16,1, 1,1, "R8 full");
        step(1,1, 0,0,0, 10,0, 1,1, "R8 hold high");
        step(1,1, 0,0,0, 1,0, 1,1, "R8 hold low level");
        step(1,1, 0,0,0, 0,0, 1,0, "R8 empty");
        step(1,1, 0,0,0, 5,0, 1,0, "R8 hold after empty");
        // R2: dropping buffering forces single style
        step(0,1, 0,0,0, 5,0, 1,1, "R2 tx forced single");

        repeat (2) @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        @(negedge clk);
        check_now("R1 mid-run reset", 1'b1, 1'b0);
        done = 1'b1;
        finish_run();
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog expired");
            finish_run();
        end
    end

endmodule